// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block takes the two-wire clock and data bus of a PS/2 keyboard or mouse and acts as the host side of device-to-host traffic. Both raw lines are brought into the system clock domain. The clock line is then filtered so that short glitches cannot count as edges. Data is captured on each accepted falling edge of the device clock. Once eleven bits are in, the block checks the frame and either hands the byte on with a one-cycle valid strobe or raises a one-cycle error pulse.

A stalled frame is abandoned after a programmable number of system cycles without a clock edge, so a lost bit cannot misalign the frames that follow. The host can also stop the device from sending through an inhibit request. While inhibit is asserted, the block pulls the clock line low through an open-drain enable and throws away any partial frame.

Top module: `ps2_rx_host`

## Requirements
- R1: A frame is a start bit of 0, then eight data bits with the least significant bit first, then a parity bit, then a stop bit of 1. For a correct frame, `data_o` takes the byte and `valid_o` is high for exactly one system cycle, a few cycles after the eleventh accepted falling edge.
- R2: A bit is sampled only on a falling edge of the filtered clock. A low pulse on the clock line that lasts fewer than `FILT_CYC` system cycles is ignored and does not shift the frame.
- R3: When the eight data bits and the parity bit together hold an even number of ones, `parity_err_o` pulses for one cycle, `valid_o` stays low and `data_o` keeps its previous value.
- R4: When the start bit is 1 or the stop bit is 0, `frame_err_o` pulses for one cycle, `valid_o` and `parity_err_o` stay low and `data_o` keeps its previous value.
- R5: If no falling edge arrives for `TIMEOUT_CYC` system cycles while a frame is partly received, the partial frame is dropped and the next complete frame is received correctly. A gap shorter than the timeout does not break the frame.
- R6: `clk_oe_o` is high in the cycle after `inhibit_i` is high and low in the cycle after it is low. A partial frame in progress when inhibit is applied is discarded, and no pulse is produced while inhibit is high.
- R7: After reset, `valid_o`, `frame_err_o`, `parity_err_o` and `clk_oe_o` are 0 and `data_o` is 0x00.
- R8: Frames sent back to back, with only one clock period between them, are each received, including the all-ones and all-zeros bytes.
- R9: `valid_o`, `frame_err_o` and `parity_err_o` are never high together, and each is high for at most one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Raw PS/2 clock line level |
| ps2_dat_i | input | 1 | Raw PS/2 data line level |
| inhibit_i | input | 1 | Request to hold the device off the bus |
| data_o | output | 8 | Last correctly received byte |
| valid_o | output | 1 | One-cycle strobe for a new byte |
| frame_err_o | output | 1 | One-cycle pulse for a bad start or stop bit |
| parity_err_o | output | 1 | One-cycle pulse for an odd-parity failure |
| clk_oe_o | output | 1 | Open-drain enable that pulls the clock line low |

## Verification
A bit counter that slips, or a shift position that is off by one, shows on the first following frame as a wrong `data_o`, a false error pulse or a missing strobe, within about 11 device clock periods. A filter that is too permissive lets a glitch shift the frame. That makes the byte come out wrong or turns it into a framing error on the same frame. A broken timeout or inhibit path leaves stale bits in the counter, so the next full frame misaligns and surfaces as an error pulse instead of a valid byte.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int unsigned DATA_BITS  = 8;
  localparam int unsigned FRAME_BITS = DATA_BITS + 3;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

  typedef logic [DATA_BITS-1:0] byte_t;

  // true when data plus parity hold an odd number of ones
  function automatic logic odd_ok(input byte_t d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ps2_clk_filter.sv
module ps2_clk_filter #(
  parameter int unsigned FILT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_s_i,
  input  logic dat_s_i,
  output logic level_o,
  output logic fall_o,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_o <= 1'b1;
      fall_o  <= 1'b0;
      bit_o   <= 1'b1;
    end else begin
      fall_o <= 1'b0;
      if (clk_s_i == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        level_o <= clk_s_i;
        fall_o  <= ~clk_s_i;
        bit_o   <= dat_s_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  // R2
  fall_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !level_o);
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fall_i,
  input  logic  bit_i,
  input  logic  inhibit_i,
  output byte_t data_o,
  output logic  valid_o,
  output logic  frame_err_o,
  output logic  parity_err_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0]    T_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] B_LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0]      cnt_q;
  logic [TW-1:0]         tmr_q;
  logic [FRAME_BITS-2:0] sh_q;   // start, data, parity
  logic                  start_ok, stop_ok, frame_ok, par_ok;

  assign start_ok = ~sh_q[0];
  assign stop_ok  = bit_i;
  assign frame_ok = start_ok & stop_ok;
  assign par_ok   = odd_ok(sh_q[DATA_BITS:1], sh_q[DATA_BITS+1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      tmr_q        <= '0;
      sh_q         <= '0;
      data_o       <= '0;
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      if (inhibit_i) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else if (fall_i) begin
        tmr_q <= '0;
        if (cnt_q == B_LAST) begin
          cnt_q        <= '0;
          frame_err_o  <= ~frame_ok;
          parity_err_o <= frame_ok & ~par_ok;
          valid_o      <= frame_ok & par_ok;
          if (frame_ok && par_ok) data_o <= sh_q[DATA_BITS:1];
        end else begin
          sh_q[cnt_q] <= bit_i;
          cnt_q       <= cnt_q + 1'b1;
        end
      end else if (cnt_q != '0) begin
        if (tmr_q == T_LAST) begin
          cnt_q <= '0;
          tmr_q <= '0;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= B_LAST);

  // R9
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({valid_o, frame_err_o, parity_err_o}) <= 1);

  // R9
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(data_o) |-> valid_o);

  // R6
  inhibit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !valid_o && !frame_err_o && !parity_err_o && cnt_q == '0);

  // R5
  timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q == T_LAST && !fall_i && !inhibit_i) |=> cnt_q == '0);
endmodule

// File: rtl/ps2_rx_host.sv
module ps2_rx_host
  import ps2_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 16,
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  input  logic       inhibit_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       frame_err_o,
  output logic       parity_err_o,
  output logic       clk_oe_o
);
  logic clk_s, dat_s, level, fall, smp;

  ps2_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk_i, .rst_ni, .d_i(ps2_clk_i), .q_o(clk_s));

  ps2_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
    .clk_i, .rst_ni, .d_i(ps2_dat_i), .q_o(dat_s));

  ps2_clk_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i, .rst_ni, .clk_s_i(clk_s), .dat_s_i(dat_s),
    .level_o(level), .fall_o(fall), .bit_o(smp));

  ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
    .clk_i, .rst_ni, .fall_i(fall), .bit_i(smp), .inhibit_i,
    .data_o, .valid_o, .frame_err_o, .parity_err_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_oe_o <= 1'b0;
    else         clk_oe_o <= inhibit_i;
  end

  // R6
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_oe_o |-> !valid_o && !frame_err_o && !parity_err_o);

  // R2
  fall_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |-> !clk_s);

  logic unused_level;
  assign unused_level = level;
endmodule

// File: tb/ps2_rx_host_tb.sv
module ps2_rx_host_tb;
  localparam int FILT = 4;
  localparam int TMO  = 3000;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1, inhibit = 1'b0;
  logic [7:0] data;
  logic valid, ferr, perr, clk_oe, line_clk;

  int checks = 0, errors = 0;
  int n_valid = 0, n_ferr = 0, n_perr = 0;
  logic [7:0] last_byte;
  bit done = 0;

  always #5 clk = ~clk;
  assign line_clk = dev_clk & ~clk_oe;

  ps2_rx_host #(.FILT_CYC(FILT), .TIMEOUT_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(line_clk), .ps2_dat_i(dev_dat),
    .inhibit_i(inhibit), .data_o(data), .valid_o(valid),
    .frame_err_o(ferr), .parity_err_o(perr), .clk_oe_o(clk_oe));

  always @(negedge clk) begin
    if (valid) begin n_valid++; last_byte = data; end
    if (ferr) n_ferr++;
    if (perr) n_perr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input bit bad_par,
                                     input bit st, input bit sp);
    logic p;
    p = ~^d;
    if (bad_par) p = ~p;
    return {sp, p, d, st};
  endfunction

  task automatic send_bits(input logic [10:0] f, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      dev_dat = f[i];
      cyc(HALF/2);
      dev_clk = 1'b0;
      cyc(HALF);
      dev_clk = 1'b1;
      cyc(HALF/2);
    end
  endtask

  task automatic expect_counts(input string req, input int v0, input int f0, input int p0,
                               input int dv, input int df, input int dp);
    chk(n_valid - v0 == dv, req, n_valid - v0, dv);
    chk(n_ferr - f0 == df, req, n_ferr - f0, df);
    chk(n_perr - p0 == dp, req, n_perr - p0, dp);
  endtask

  task automatic t_reset();
    cyc(2);
    chk(data == 8'h00, "R7", data, 0);
    chk({valid, ferr, perr, clk_oe} == 4'b0, "R7", {valid, ferr, perr, clk_oe}, 0);
  endtask

  task automatic t_good(input logic [7:0] d, input string req);
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    send_bits(mk(d, 0, 0, 1), 0, 10);
    cyc(20);
    expect_counts(req, v0, f0, p0, 1, 0, 0);
    chk(last_byte == d && data == d, req, data, d);
  endtask

  task automatic t_back2back();
    int v0 = n_valid;
    send_bits(mk(8'hFF, 0, 0, 1), 0, 10);
    send_bits(mk(8'h00, 0, 0, 1), 0, 10);
    send_bits(mk(8'h81, 0, 0, 1), 0, 10);
    cyc(20);
    chk(n_valid - v0 == 3, "R8", n_valid - v0, 3);
    chk(data == 8'h81, "R8", data, 8'h81);
  endtask

  task automatic t_parity();
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    logic [7:0] prev = data;
    send_bits(mk(8'h5A, 1, 0, 1), 0, 10);
    cyc(20);
    expect_counts("R3", v0, f0, p0, 0, 0, 1);
    chk(data == prev, "R3", data, prev);
  endtask

  task automatic t_framing(input bit st, input bit sp);
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    logic [7:0] prev = data;
    send_bits(mk(8'h96, 0, st, sp), 0, 10);
    cyc(20);
    expect_counts("R4", v0, f0, p0, 0, 1, 0);
    chk(data == prev, "R4", data, prev);
  endtask

  task automatic t_glitch();
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    logic [10:0] f = mk(8'hC3, 0, 0, 1);
    send_bits(f, 0, 4);
    cyc(5);
    dev_clk = 1'b0; cyc(FILT - 2); dev_clk = 1'b1;   // too short to count
    cyc(10);
    send_bits(f, 5, 10);
    cyc(20);
    expect_counts("R2", v0, f0, p0, 1, 0, 0);
    chk(data == 8'hC3, "R2", data, 8'hC3);
  endtask

  task automatic t_timeout();
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    logic [10:0] f = mk(8'h27, 0, 0, 1);
    send_bits(f, 0, 4);
    cyc(TMO - 1000);                  // gap under the limit keeps the frame
    send_bits(f, 5, 10);
    cyc(20);
    expect_counts("R5", v0, f0, p0, 1, 0, 0);
    chk(data == 8'h27, "R5", data, 8'h27);
    v0 = n_valid; f0 = n_ferr; p0 = n_perr;
    send_bits(mk(8'h11, 0, 0, 1), 0, 5);
    cyc(TMO + 200);                   // stalled frame dropped
    send_bits(mk(8'h6E, 0, 0, 1), 0, 10);
    cyc(20);
    expect_counts("R5", v0, f0, p0, 1, 0, 0);
    chk(data == 8'h6E, "R5", data, 8'h6E);
  endtask

  task automatic t_inhibit();
    int v0 = n_valid, f0 = n_ferr, p0 = n_perr;
    send_bits(mk(8'h44, 0, 0, 1), 0, 3);
    inhibit = 1'b1;
    cyc(1);
    chk(clk_oe == 1'b1, "R6", clk_oe, 1);
    cyc(200);
    chk(line_clk == 1'b0, "R6", line_clk, 0);
    inhibit = 1'b0;
    cyc(1);
    chk(clk_oe == 1'b0, "R6", clk_oe, 0);
    cyc(100);
    expect_counts("R6", v0, f0, p0, 0, 0, 0);
    send_bits(mk(8'hB8, 0, 0, 1), 0, 10);
    cyc(20);
    expect_counts("R6", v0, f0, p0, 1, 0, 0);
    chk(data == 8'hB8, "R6", data, 8'hB8);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_good(8'hA5, "R1");
    t_good(8'h3C, "R1");
    t_back2back();
    t_parity();
    t_framing(1'b1, 1'b1);
    t_framing(1'b0, 1'b0);
    t_glitch();
    t_timeout();
    t_inhibit();
    t_good(8'h01, "R9");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule